// File: doc/BRIEF.md
# Virtual Function Enable and Routing ID Controller

This block holds the virtualization control state of one physical function and turns a virtual function index into the 16-bit routing ID that function uses on the link. Software reaches the state through a small register port: it sizes the VF population, picks a system page size, and enables the VFs and their memory decode. The block checks each write and refuses a value outside the legal range. A refused write leaves the register as it was and raises an error flag for one cycle.

Lookups are independent of the register port. The requester presents a VF index and the physical function's own routing ID. One cycle later the block returns the routed ID and a flag saying whether that VF exists at present. The conventional reset (active-low `rst_ni`) and a function-level reset pulse (`flr_i`) both return every settable field to its default. After either reset no VF is allocated or enabled.

Register map (word address on `addr_i`):

| Address | Field | Access |
|---|---|---|
| 0 | control: bit0 VF enable, bit1 migration enable, bit2 VF memory enable, bit3 migration capable | bits 0 to 2 read/write, bit 3 read-only |
| 1 | VF count, bits 15:0 | read/write |
| 2 | system page size, one-hot | read/write |
| 3 | maximum VFs in bits 31:16, initial VFs in bits 15:0 | read-only |
| 4 | supported page sizes mask | read-only |
| 5 | VF stride in bits 31:16, first VF offset in bits 15:0 | read-only |

Top module: `vfc_top`

## Requirements
- R1: After the conventional reset, the control register reads 0x8, the VF count reads 0, the page size reads 0x1, and `err_o`, `valid_o`, `vf_en_o` and `vf_mem_en_o` are low. The value 0x8 is the migration-capable bit alone.
- R2: The read-only words return these values from the default parameters: address 3 reads 0x0010_0008, address 4 reads 0x0000_0553, and address 5 reads 0x0002_0001.
- R3: While migration enable (control bit1) is clear, a VF count write is accepted only if its value is between 1 and the initial VF count (8). Any other value leaves the count unchanged and sets `err_o` for the one cycle after the write.
- R4: While migration enable is set and the block is migration capable, the upper bound for the VF count becomes the maximum VF count (16). A control write that clears migration enable while the count is above the initial VF count is rejected with `err_o`.
- R5: While VF enable is set, writes to the VF count are ignored and raise no error.
- R6: A control write that sets VF enable while the VF count is 0 is rejected with `err_o`, and the control register keeps its value.
- R7: A page size write is accepted only if it has exactly one bit set and that bit is in the supported mask. Any other write is rejected with `err_o`.
- R8: `rid_o` equals (`pf_rid_i` + first offset + (index − 1) × stride) mod 2^16, one cycle after the index is presented.
- R9: `valid_o` is high only when VF enable is set and the index lies in 1..VF count. It is low for index 0, for an index above the count, and whenever VF enable is clear.
- R10: A one-cycle `flr_i` pulse clears VF enable, migration enable, memory enable and the VF count, and restores the page size to 0x1.
- R11: `vf_en_o` follows control bit0. `vf_mem_en_o` is high only when both bit0 and bit2 are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous active-low conventional reset |
| flr_i | input | 1 | function-level reset pulse for the physical function |
| wr_en_i | input | 1 | register write strobe |
| addr_i | input | 3 | register word address |
| wdata_i | input | 32 | write data |
| rdata_o | output | 32 | read data for `addr_i`, combinational |
| err_o | output | 1 | one-cycle pulse after a rejected write |
| pf_rid_i | input | 16 | routing ID of the physical function |
| vf_idx_i | input | 16 | VF index to look up |
| rid_o | output | 16 | routing ID of the looked-up VF |
| valid_o | output | 1 | the looked-up VF is active |
| vf_en_o | output | 1 | VFs enabled |
| vf_mem_en_o | output | 1 | VF memory decode enabled |

## Verification
Read data is combinational, so the bench checks it in the same half-cycle in which it sets the address. `err_o`, the register contents and `vf_en_o`/`vf_mem_en_o` change on the first rising edge after a write, and the bench samples them on the falling edge that follows that edge. `rid_o` and `valid_o` are registered once, so each lookup is checked one edge after the index is driven. All stimulus changes on the falling edge, and all checks are made there.

// File: rtl/vfc_pkg.sv
package vfc_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned RID_W  = 16;

  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] A_NUMVF = 3'd1;
  localparam logic [ADDR_W-1:0] A_PAGE  = 3'd2;
  localparam logic [ADDR_W-1:0] A_COUNT = 3'd3;
  localparam logic [ADDR_W-1:0] A_SUPP  = 3'd4;
  localparam logic [ADDR_W-1:0] A_STEP  = 3'd5;

  localparam int unsigned B_EN  = 0;
  localparam int unsigned B_MIG = 1;
  localparam int unsigned B_MSE = 2;
  localparam int unsigned B_CAP = 3;

  localparam logic [DATA_W-1:0] PAGE_DEF = 32'h1;

  typedef struct packed {
    logic mse;
    logic mig_en;
    logic vf_en;
  } ctrl_t;
endpackage

// File: rtl/vfc_regs.sv
module vfc_regs
  import vfc_pkg::*;
#(
  parameter int unsigned          TOTAL_VFS   = 16,
  parameter int unsigned          INITIAL_VFS = 8,
  parameter bit                   MIG_CAP     = 1'b1,
  parameter logic [DATA_W-1:0]    SUPP_PAGES  = 32'h553,
  parameter logic [RID_W-1:0]     FIRST_OFS   = 16'd1,
  parameter logic [RID_W-1:0]     VF_STRIDE   = 16'd2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flr_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              err_o,
  output logic [RID_W-1:0]  num_vfs_o,
  output logic              vf_en_o,
  output logic              vf_mse_o
);
  localparam logic [RID_W-1:0] TOT_W  = RID_W'(TOTAL_VFS);
  localparam logic [RID_W-1:0] INIT_W = RID_W'(INITIAL_VFS);

  ctrl_t              ctrl_q;
  logic [RID_W-1:0]   num_q;
  logic [DATA_W-1:0]  page_q;
  logic               err_q;

  logic [RID_W-1:0]   lim_cur, lim_new;
  logic               mig_new, num_ok, ctrl_ok, page_ok, bad;
  logic               wr_num, wr_ctrl, wr_page;

  always_comb begin
    wr_num  = wr_en_i && addr_i == A_NUMVF;
    wr_ctrl = wr_en_i && addr_i == A_CTRL;
    wr_page = wr_en_i && addr_i == A_PAGE;

    lim_cur = (MIG_CAP && ctrl_q.mig_en) ? TOT_W : INIT_W;
    mig_new = MIG_CAP && wdata_i[B_MIG];
    lim_new = mig_new ? TOT_W : INIT_W;

    num_ok  = wdata_i[RID_W-1:0] != '0 && wdata_i[RID_W-1:0] <= lim_cur;
    ctrl_ok = !(wdata_i[B_EN] && num_q == '0) && num_q <= lim_new;
    page_ok = wdata_i != '0 && (wdata_i & (wdata_i - 1'b1)) == '0
              && (wdata_i & ~SUPP_PAGES) == '0;

    bad = (wr_num && !ctrl_q.vf_en && !num_ok) ||
          (wr_ctrl && !ctrl_ok) || (wr_page && !page_ok);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      num_q  <= '0;
      page_q <= PAGE_DEF;
      err_q  <= 1'b0;
    end else if (flr_i) begin
      ctrl_q <= '0;
      num_q  <= '0;
      page_q <= PAGE_DEF;
      err_q  <= 1'b0;
    end else begin
      err_q <= bad;
      if (wr_num && !ctrl_q.vf_en && num_ok) num_q <= wdata_i[RID_W-1:0];
      if (wr_ctrl && ctrl_ok) begin
        ctrl_q.vf_en  <= wdata_i[B_EN];
        ctrl_q.mig_en <= mig_new;
        ctrl_q.mse    <= wdata_i[B_MSE];
      end
      if (wr_page && page_ok) page_q <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CTRL: begin
        rdata_o[B_EN]  = ctrl_q.vf_en;
        rdata_o[B_MIG] = ctrl_q.mig_en;
        rdata_o[B_MSE] = ctrl_q.mse;
        rdata_o[B_CAP] = MIG_CAP;
      end
      A_NUMVF: rdata_o = {{(DATA_W-RID_W){1'b0}}, num_q};
      A_PAGE:  rdata_o = page_q;
      A_COUNT: rdata_o = {TOT_W, INIT_W};
      A_SUPP:  rdata_o = SUPP_PAGES;
      A_STEP:  rdata_o = {VF_STRIDE, FIRST_OFS};
      default: rdata_o = '0;
    endcase
  end

  assign err_o     = err_q;
  assign num_vfs_o = num_q;
  assign vf_en_o   = ctrl_q.vf_en;
  assign vf_mse_o  = ctrl_q.mse;

  a_r3_zero_count_rejected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && addr_i == A_NUMVF && wdata_i[RID_W-1:0] == '0 && !flr_i && !ctrl_q.vf_en
    |=> $stable(num_q) && err_o);

  a_r4_count_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    num_q <= TOT_W);

  a_r5_count_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && addr_i == A_NUMVF && ctrl_q.vf_en && !flr_i
    |=> $stable(num_q) && !err_o);

  a_r6_enable_needs_vfs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q.vf_en |-> num_q != '0);

  a_r7_page_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(page_q));

  a_r10_flr_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flr_i |=> num_q == '0 && !ctrl_q.vf_en && !ctrl_q.mse && !err_o);
endmodule

// File: rtl/vfc_rid.sv
module vfc_rid
  import vfc_pkg::*;
#(
  parameter logic [RID_W-1:0] FIRST_OFS = 16'd1,
  parameter logic [RID_W-1:0] VF_STRIDE = 16'd2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [RID_W-1:0] pf_rid_i,
  input  logic [RID_W-1:0] vf_idx_i,
  input  logic [RID_W-1:0] num_vfs_i,
  input  logic             vf_en_i,
  output logic [RID_W-1:0] rid_o,
  output logic             valid_o
);
  logic [RID_W-1:0] idx_m1, step, rid_d;
  logic             hit_d;

  // all sums kept at 16 bits so carries fall off
  always_comb begin
    idx_m1 = vf_idx_i - 1'b1;
    step   = idx_m1 * VF_STRIDE;
    rid_d  = pf_rid_i + FIRST_OFS + step;
    hit_d  = vf_en_i && vf_idx_i != '0 && vf_idx_i <= num_vfs_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rid_o   <= '0;
      valid_o <= 1'b0;
    end else begin
      rid_o   <= rid_d;
      valid_o <= hit_d;
    end
  end

  a_r9_valid_nonzero_idx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(vf_idx_i) != '0 && $past(vf_en_i));

  a_r9_valid_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(vf_idx_i) <= $past(num_vfs_i));
endmodule

// File: rtl/vfc_top.sv
module vfc_top
  import vfc_pkg::*;
#(
  parameter int unsigned       TOTAL_VFS   = 16,
  parameter int unsigned       INITIAL_VFS = 8,
  parameter bit                MIG_CAP     = 1'b1,
  parameter logic [31:0]       SUPP_PAGES  = 32'h553,
  parameter logic [15:0]       FIRST_OFS   = 16'd1,
  parameter logic [15:0]       VF_STRIDE   = 16'd2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        flr_i,
  input  logic        wr_en_i,
  input  logic [2:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        err_o,
  input  logic [15:0] pf_rid_i,
  input  logic [15:0] vf_idx_i,
  output logic [15:0] rid_o,
  output logic        valid_o,
  output logic        vf_en_o,
  output logic        vf_mem_en_o
);
  logic [RID_W-1:0] num_vfs;
  logic             vf_en, vf_mse;

  vfc_regs #(
    .TOTAL_VFS(TOTAL_VFS), .INITIAL_VFS(INITIAL_VFS), .MIG_CAP(MIG_CAP),
    .SUPP_PAGES(SUPP_PAGES), .FIRST_OFS(FIRST_OFS), .VF_STRIDE(VF_STRIDE)
  ) u_regs (
    .clk_i, .rst_ni, .flr_i, .wr_en_i, .addr_i, .wdata_i, .rdata_o, .err_o,
    .num_vfs_o(num_vfs), .vf_en_o(vf_en), .vf_mse_o(vf_mse)
  );

  vfc_rid #(.FIRST_OFS(FIRST_OFS), .VF_STRIDE(VF_STRIDE)) u_rid (
    .clk_i, .rst_ni, .pf_rid_i, .vf_idx_i,
    .num_vfs_i(num_vfs), .vf_en_i(vf_en), .rid_o, .valid_o
  );

  assign vf_en_o     = vf_en;
  assign vf_mem_en_o = vf_en && vf_mse;

  a_r11_mem_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vf_mem_en_o |-> vf_en_o);
endmodule

// File: tb/sim_vfc_top.sv
module sim_vfc_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        flr_i = 1'b0, wr_en_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [31:0] wdata_i = '0, rdata_o;
  logic        err_o, valid_o, vf_en_o, vf_mem_en_o;
  logic [15:0] pf_rid_i = 16'h0200, vf_idx_i = '0, rid_o;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  vfc_top u0 (.clk_i(clk), .*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d, logic exp_err, string req);
    @(negedge clk);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk);
    @(negedge clk);
    wr_en_i = 1'b0;
    chk(req, {31'd0, err_o}, {31'd0, exp_err});
  endtask

  task automatic rd(logic [2:0] a, logic [31:0] exp, string req);
    addr_i = a;
    #1;
    chk(req, rdata_o, exp);
  endtask

  task automatic look(logic [15:0] idx, logic [15:0] exp_rid, logic exp_v, bit cmp_rid, string req);
    @(negedge clk);
    vf_idx_i = idx;
    @(posedge clk);
    @(negedge clk);
    chk(req, {31'd0, valid_o}, {31'd0, exp_v});
    if (cmp_rid) chk(req, {16'd0, rid_o}, {16'd0, exp_rid});
  endtask

  task automatic t_reset;
    rd(3'd0, 32'h8, "R1 ctrl");
    rd(3'd1, 32'h0, "R1 count");
    rd(3'd2, 32'h1, "R1 page");
    chk("R1 outputs", {28'd0, err_o, valid_o, vf_en_o, vf_mem_en_o}, 32'h0);
    look(16'd1, 16'h0, 1'b0, 1'b0, "R1 no vf");
  endtask

  task automatic t_caps;
    rd(3'd3, 32'h0010_0008, "R2 counts");
    rd(3'd4, 32'h0000_0553, "R2 pages");
    rd(3'd5, 32'h0002_0001, "R2 offset/stride");
  endtask

  task automatic t_count_range;
    wr(3'd1, 32'd0, 1'b1, "R3 zero");
    rd(3'd1, 32'd0, "R3 zero kept");
    wr(3'd1, 32'd9, 1'b1, "R3 above initial");
    rd(3'd1, 32'd0, "R3 above kept");
    wr(3'd1, 32'd8, 1'b0, "R3 at initial");
    rd(3'd1, 32'd8, "R3 accepted");
    @(negedge clk);
    chk("R3 err one cycle", {31'd0, err_o}, 32'd0);
  endtask

  task automatic t_migration;
    wr(3'd0, 32'h2, 1'b0, "R4 mig on");
    rd(3'd0, 32'hA, "R4 ctrl");
    wr(3'd1, 32'd16, 1'b0, "R4 at total");
    rd(3'd1, 32'd16, "R4 count 16");
    wr(3'd1, 32'd17, 1'b1, "R4 above total");
    wr(3'd0, 32'h0, 1'b1, "R4 clear mig blocked");
    rd(3'd0, 32'hA, "R4 ctrl kept");
    wr(3'd1, 32'd4, 1'b0, "R4 shrink");
    wr(3'd0, 32'h0, 1'b0, "R4 clear mig");
    rd(3'd0, 32'h8, "R4 ctrl cleared");
  endtask

  task automatic t_enable;
    wr(3'd0, 32'h5, 1'b0, "R11 enable+mse");
    chk("R11 outs", {30'd0, vf_en_o, vf_mem_en_o}, 32'h3);
    wr(3'd1, 32'd2, 1'b0, "R5 no err");
    rd(3'd1, 32'd4, "R5 count held");
    wr(3'd0, 32'h1, 1'b0, "R11 mse off");
    chk("R11 outs mse off", {30'd0, vf_en_o, vf_mem_en_o}, 32'h2);
  endtask

  task automatic t_rid;
    pf_rid_i = 16'h0200;
    look(16'd1, 16'h0201, 1'b1, 1'b1, "R8 first");
    look(16'd4, 16'h0207, 1'b1, 1'b1, "R8 last");
    look(16'd5, 16'h0209, 1'b0, 1'b1, "R9 above count");
    look(16'd0, 16'h0, 1'b0, 1'b0, "R9 index zero");
    pf_rid_i = 16'hFFFC;
    look(16'd3, 16'h0001, 1'b1, 1'b1, "R8 wrap");
    pf_rid_i = 16'h0200;
    wr(3'd0, 32'h0, 1'b0, "R9 disable");
    look(16'd1, 16'h0201, 1'b0, 1'b0, "R9 disabled");
  endtask

  task automatic t_page;
    wr(3'd2, 32'h2, 1'b0, "R7 supported");
    rd(3'd2, 32'h2, "R7 taken");
    wr(3'd2, 32'h4, 1'b1, "R7 unsupported");
    wr(3'd2, 32'h3, 1'b1, "R7 two bits");
    wr(3'd2, 32'h0, 1'b1, "R7 zero");
    rd(3'd2, 32'h2, "R7 kept");
  endtask

  task automatic t_flr;
    wr(3'd0, 32'h5, 1'b0, "R10 prep");
    @(negedge clk); flr_i = 1'b1;
    @(negedge clk); flr_i = 1'b0;
    rd(3'd0, 32'h8, "R10 ctrl");
    rd(3'd1, 32'h0, "R10 count");
    rd(3'd2, 32'h1, "R10 page");
    chk("R10 outs", {30'd0, vf_en_o, vf_mem_en_o}, 32'h0);
    look(16'd1, 16'h0, 1'b0, 1'b0, "R10 no vf");
    wr(3'd0, 32'h1, 1'b1, "R6 enable with zero");
    rd(3'd0, 32'h8, "R6 ctrl kept");
  endtask

  task automatic t_hard_reset;
    wr(3'd1, 32'd3, 1'b0, "R1 prep count");
    wr(3'd0, 32'h5, 1'b0, "R1 prep en");
    @(negedge clk); rst_ni = 1'b0;
    @(negedge clk); rst_ni = 1'b1;
    rd(3'd0, 32'h8, "R1 ctrl after reset");
    rd(3'd1, 32'h0, "R1 count after reset");
    chk("R1 outs after reset", {30'd0, vf_en_o, vf_mem_en_o}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_caps();
    t_count_range();
    t_migration();
    t_enable();
    t_rid();
    t_page();
    t_flr();
    t_hard_reset();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule